// File: doc/BRIEF.md
# Receive Queue with Error Tallies and Read-Armed Status Flags

This block is the receive side buffer of a serial port. A receiver pushes each byte into a 16-entry queue. Along with the byte it pushes two tags: one for a parity error and one for a framing error. The CPU takes bytes out through a pop port. Each pop updates a registered data output one cycle after the pop.

A 16-bit status word is always visible on a register read bus. The upper byte holds two live tallies. Bits 15:12 count how many queued entries carry a parity tag. Bits 11:8 count how many carry a framing tag. Each tally is four bits wide, so a full queue in which every entry is tagged reads as zero. Bits 3 and 2 show the framing and parity tags of the entry at the head of the queue.

The remaining six bits are sticky event flags. Each flag is raised by its own set pulse. Software may clear a flag only after a register read has seen that flag at one. After that read, a write with a zero in the flag's position clears it.

Top module: `rxq_status_reg`

## Requirements
- R1: After reset the status word reads 0x0060, the queue is empty and overrun is low.
- R2: Bytes leave the queue in push order, up to 16 entries. `pop_data` shows the popped byte in the cycle after a pop.
- R3: Bits 15:12 equal the number of queued entries with a parity tag. The count rises on an accepted tagged push and falls on a pop of a tagged entry. A tagged push and a tagged pop in the same cycle leave it unchanged.
- R4: Bits 11:8 follow the same rules as R3, but for framing-tagged entries.
- R5: When 16 queued entries all carry the same tag, that tally field reads 0.
- R6: Bit 3 shows the framing tag of the head entry and bit 2 shows its parity tag. Both read 0 while the queue is empty.
- R7: A register write never changes bits 15:8 or bits 3:2.
- R8: The sticky flags sit at bit 7 (receive error, `flag_set[5]`), bit 6 (transmit end, `flag_set[4]`), bit 5 (transmit queue empty, `flag_set[3]`), bit 4 (break, `flag_set[2]`), bit 1 (receive full, `flag_set[1]`) and bit 0 (data ready, `flag_set[0]`). Writing 1 to a flag bit never changes that flag.
- R9: A write of 0 clears a flag only if a read (`reg_rd`) saw that flag at 1 after it was last raised. Otherwise the write is ignored.
- R10: A set pulse that arrives in the same cycle as a clearing write wins, and the flag stays 1. A further read is then needed before the flag can be cleared.
- R11: A push into a full queue is dropped, even if a pop occurs in the same cycle. `overrun` is high for the one cycle after the dropped push.
- R12: A pop from an empty queue leaves `pop_data` and both tallies unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| push_valid | input | 1 | Push one byte from the receiver |
| push_data | input | 8 | Byte to push |
| push_perr | input | 1 | Parity-error tag of the pushed byte |
| push_ferr | input | 1 | Framing-error tag of the pushed byte |
| pop_req | input | 1 | CPU pops the head entry |
| pop_data | output | 8 | Most recently popped byte |
| overrun | output | 1 | Push was dropped because the queue was full |
| reg_rd | input | 1 | Status read strobe (arms the flags that read as 1) |
| reg_wr | input | 1 | Status write strobe |
| reg_wdata | input | 16 | Status write data |
| reg_rdata | output | 16 | Status word |
| flag_set | input | 6 | Set pulses for the six sticky flags |

## Verification
Two pairs of events can land in the same cycle, and each needs a defined outcome. The first pair is a push and a pop that both move the same tally. The bench drives a tagged push together with a pop of an entry carrying the same tag, and expects that tally to stay unchanged. It also drives a push into a full queue together with a pop, and expects the push to be dropped. The second pair is a flag's set pulse and a clearing write to that same flag. The bench arms the flag by a read, then issues the write and the pulse in the same cycle. It expects the flag to remain 1 and to survive a second write of 0 until it is read again.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int DATA_W  = 8;
    localparam int NFLAG   = 6;
    localparam int FIELD_W = 4;
    // flag index: 0 data ready, 1 rx full, 2 break, 3 tx empty, 4 tx end, 5 rx error
    localparam logic [NFLAG-1:0] FLAG_RST = 6'b011000;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push_valid,
    input  rxq_entry_t              push_entry,
    input  logic                    pop_req,
    output rxq_entry_t              head,
    output logic                    empty,
    output logic [DATA_W-1:0]       pop_data,
    output logic [$clog2(DEPTH):0]  perr_cnt,
    output logic [$clog2(DEPTH):0]  ferr_cnt,
    output logic                    overrun
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        rxq_entry_t [DEPTH-1:0] mem;
        logic [AW-1:0]          wptr;
        logic [AW-1:0]          rptr;
        logic [CW-1:0]          cnt;
        logic [CW-1:0]          pcnt;
        logic [CW-1:0]          fcnt;
        logic [DATA_W-1:0]      pop_data;
        logic                   overrun;
    } st_t;

    st_t s_d, s_q;
    logic do_push, do_pop, is_full;
    rxq_entry_t head_e;

    always_comb begin
        s_d     = s_q;
        is_full = (s_q.cnt == FULL_CNT);
        do_push = push_valid && !is_full;
        do_pop  = pop_req && (s_q.cnt != '0);
        head_e  = s_q.mem[s_q.rptr];

        if (do_push) begin
            s_d.mem[s_q.wptr] = push_entry;
            s_d.wptr          = s_q.wptr + 1'b1;
        end
        if (do_pop) begin
            s_d.pop_data = head_e.data;
            s_d.rptr     = s_q.rptr + 1'b1;
        end
        s_d.cnt  = s_q.cnt  + CW'(do_push) - CW'(do_pop);
        s_d.pcnt = s_q.pcnt + CW'(do_push && push_entry.perr) - CW'(do_pop && head_e.perr);
        s_d.fcnt = s_q.fcnt + CW'(do_push && push_entry.ferr) - CW'(do_pop && head_e.ferr);
        s_d.overrun = push_valid && is_full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign head     = head_e;
    assign empty    = (s_q.cnt == '0);
    assign pop_data = s_q.pop_data;
    assign perr_cnt = s_q.pcnt;
    assign ferr_cnt = s_q.fcnt;
    assign overrun  = s_q.overrun;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= FULL_CNT); // R2
    AST_PCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pcnt <= s_q.cnt); // R3
    AST_FCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fcnt <= s_q.cnt); // R4
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && s_q.cnt == FULL_CNT && !pop_req) |=> ($stable(s_q.cnt) && overrun)); // R11
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && s_q.cnt == '0 && !push_valid) |=> ($stable(pop_data) && $stable(perr_cnt) && $stable(ferr_cnt))); // R12
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
    import rxq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] flag_set,
    input  logic             rd,
    input  logic             wr,
    input  logic [NFLAG-1:0] wr_bits,
    output logic [NFLAG-1:0] flags
);
    typedef struct packed {
        logic [NFLAG-1:0] flg;
        logic [NFLAG-1:0] arm;
    } st_t;

    st_t s_d, s_q;
    logic [NFLAG-1:0] clr, seen;

    always_comb begin
        s_d   = s_q;
        seen  = rd ? s_q.flg : '0;
        clr   = wr ? (~wr_bits & s_q.arm & s_q.flg) : '0;
        s_d.flg = (s_q.flg & ~clr) | flag_set;
        s_d.arm = (s_q.arm | seen) & ~clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.flg <= FLAG_RST;
            s_q.arm <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign flags = s_q.flg;

    AST_W1_NOEFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((s_q.flg & $past(~s_q.flg & ~flag_set)) == '0)); // R8
    AST_CLR_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~s_q.flg & $past(s_q.flg) & ~$past(s_q.arm)) == '0)); // R9
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_set) |=> ((s_q.flg & $past(flag_set)) == $past(flag_set))); // R10
endmodule

// File: rtl/rxq_status_reg.sv
module rxq_status_reg
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push_valid,
    input  logic [7:0]          push_data,
    input  logic                push_perr,
    input  logic                push_ferr,
    input  logic                pop_req,
    output logic [7:0]          pop_data,
    output logic                overrun,
    input  logic                reg_rd,
    input  logic                reg_wr,
    input  logic [15:0]         reg_wdata,
    output logic [15:0]         reg_rdata,
    input  logic [5:0]          flag_set
);
    localparam int CW = $clog2(DEPTH) + 1;

    rxq_entry_t       in_e, head_e;
    logic             empty;
    logic [CW-1:0]    pcnt, fcnt;
    logic [NFLAG-1:0] flags, wbits;
    logic             head_fer, head_per;

    assign in_e = '{data: push_data, perr: push_perr, ferr: push_ferr};

    rxq_store #(.DEPTH(DEPTH)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .push_entry (in_e),
        .pop_req    (pop_req),
        .head       (head_e),
        .empty      (empty),
        .pop_data   (pop_data),
        .perr_cnt   (pcnt),
        .ferr_cnt   (fcnt),
        .overrun    (overrun)
    );

    assign wbits = {reg_wdata[7:4], reg_wdata[1:0]};

    rxq_flags flags_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_set (flag_set),
        .rd       (reg_rd),
        .wr       (reg_wr),
        .wr_bits  (wbits),
        .flags    (flags)
    );

    assign head_fer  = !empty && head_e.ferr;
    assign head_per  = !empty && head_e.perr;
    assign reg_rdata = {FIELD_W'(pcnt), FIELD_W'(fcnt), flags[5:2], head_fer, head_per, flags[1:0]};

    AST_HEAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (reg_rdata[3:2] == 2'b00)); // R6
endmodule

// File: tb/rxq_status_reg_tb_top.sv
`timescale 1ns/1ps
module rxq_status_reg_tb_top;
    import rxq_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_valid = 0, push_perr = 0, push_ferr = 0, pop_req = 0;
    logic [7:0] push_data = '0;
    logic reg_rd = 0, reg_wr = 0;
    logic [15:0] reg_wdata = '0;
    logic [5:0] flag_set = '0;
    logic [7:0] pop_data;
    logic overrun;
    logic [15:0] reg_rdata;

    always #2.5 clk = ~clk;

    rxq_status_reg dut_i (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
        .push_perr(push_perr), .push_ferr(push_ferr), .pop_req(pop_req),
        .pop_data(pop_data), .overrun(overrun), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flag_set(flag_set)
    );

    int nchk = 0, nfail = 0;
    rxq_entry_t q[$];
    logic [7:0] last_data = '0;
    logic [5:0] efl = FLAG_RST;
    logic [5:0] earm = '0;

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_status();
        int pc = 0, fc = 0;
        logic hf = 0, hp = 0;
        foreach (q[i]) begin
            pc += int'(q[i].perr);
            fc += int'(q[i].ferr);
        end
        if (q.size() > 0) begin
            hf = q[0].ferr;
            hp = q[0].perr;
        end
        return {4'(pc), 4'(fc), efl[5:2], hf, hp, efl[1:0]};
    endfunction

    task automatic chk_st(string tag);
        chk(tag, reg_rdata, exp_status());
    endtask

    // scoreboard monitor: consumes expected bytes as the design pops
    always @(posedge clk) begin
        if (rst_n && pop_req) begin
            string tag;
            tag = "R12";
            if (q.size() > 0) begin
                last_data = q.pop_front().data;
                tag = "R2";
            end
            @(negedge clk);
            chk(tag, {8'h00, pop_data}, {8'h00, last_data});
        end
    end

    task automatic push(logic [7:0] d, logic p, logic f, logic with_pop = 0);
        bit acc;
        acc = q.size() < 16;
        push_valid = 1; push_data = d; push_perr = p; push_ferr = f; pop_req = with_pop;
        @(negedge clk);
        push_valid = 0; pop_req = 0;
        if (acc) q.push_back('{data: d, perr: p, ferr: f});
        else chk("R11 overrun", {15'd0, overrun}, 16'd1);
    endtask

    task automatic pop();
        pop_req = 1;
        @(negedge clk);
        pop_req = 0;
    endtask

    task automatic rd_reg();
        reg_rd = 1;
        @(negedge clk);
        reg_rd = 0;
        earm |= efl;
    endtask

    task automatic wr_reg(logic [15:0] w, logic [5:0] ev);
        logic [5:0] clr;
        reg_wr = 1; reg_wdata = w; flag_set = ev;
        @(negedge clk);
        reg_wr = 0; flag_set = '0;
        clr  = ~{w[7:4], w[1:0]} & earm & efl;
        efl  = (efl & ~clr) | ev;
        earm = earm & ~clr;
    endtask

    task automatic raise(logic [5:0] ev);
        flag_set = ev;
        @(negedge clk);
        flag_set = '0;
        efl |= ev;
    endtask

    initial begin
        #(200000 * 5);
        nfail++;
        $display("FAIL watchdog act=running exp=done");
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", reg_rdata, 16'h0060);
        chk("R1 overrun", {15'd0, overrun}, 16'd0);

        wr_reg(16'h0000, '0);            // not armed: ignored
        chk_st("R9 unarmed clear");
        wr_reg(16'hFFFF, '0);            // ones have no effect
        chk_st("R8 write ones");
        rd_reg();
        wr_reg(16'h0000, '0);
        chk_st("R9 armed clear");
        chk("R9 low byte", {8'h00, reg_rdata[7:0]}, 16'h0000);

        raise(6'b100101);
        chk_st("R8 set pulses");
        rd_reg();
        wr_reg(16'h0000, 6'b000001);     // data ready re-raised in clear cycle
        chk_st("R10 set wins");
        wr_reg(16'h0000, '0);
        chk_st("R10 needs new read");
        rd_reg();
        wr_reg(16'hFFFE, '0);
        chk_st("R9 clear bit0");

        push(8'h11, 1, 0);
        push(8'h22, 0, 1);
        push(8'h33, 1, 1);
        push(8'h44, 0, 0);
        chk_st("R3 parity tally");
        chk("R4", {12'd0, reg_rdata[11:8]}, 16'd2);
        chk("R6 head", {14'd0, reg_rdata[3:2]}, 16'd1);
        rd_reg();
        wr_reg(16'hFF0C, '0);
        chk_st("R7 read-only fields");

        push(8'h55, 1, 0, 1);            // pops parity-tagged 0x11
        chk_st("R3 push+pop");
        push(8'h66, 0, 1, 1);            // pops framing-tagged 0x22
        chk_st("R4 push+pop");
        chk("R6 head both", {14'd0, reg_rdata[3:2]}, 16'd3);

        repeat (3) pop();
        chk("R6 head fer", {14'd0, reg_rdata[3:2]}, 16'd2);
        pop();
        chk("R6 empty", {14'd0, reg_rdata[3:2]}, 16'd0);
        pop();                           // empty pop
        chk_st("R12 tallies");

        for (int i = 0; i < 16; i++) push(8'(8'hA0 + i), 1, i[0]);
        chk("R5 wrap", {12'd0, reg_rdata[15:12]}, 16'd0);
        chk("R4 half", {12'd0, reg_rdata[11:8]}, 16'd8);
        push(8'hEE, 0, 0);               // dropped
        chk_st("R11 dropped");
        push(8'hEF, 0, 0, 1);            // dropped even with pop
        chk_st("R11 full with pop");
        while (q.size() > 0) pop();
        @(negedge clk);
        chk_st("R2 drained");

        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule